// File: doc/BRIEF.md
# I/O Cycle Boundary Splitter

This block sits between the host request port and a downstream link and carries host I/O reads and writes. Each host request names an 8-byte aligned window and carries eight byte enables over it. The downstream link only moves one 4-byte lane per transaction.

A read whose enabled bytes fall in both 4-byte halves of its window is sent as two lane transactions, lower half first. The two completions are then joined into a single host response. Any other read, and every write, goes out as one lane transaction. Writes are non-posted: the host sees a response only after the downstream completion has come back.

A separate path handles I/O or configuration requests that arrive from the downstream side. These are never served. Each one triggers a dummy memory read at the start of the legacy expansion area so that a completion exists. That completion is returned with an unsupported-request status.

Top module: `io_split_bridge`

## Requirements
- R1: A read with enables in only one half goes out as one transaction. The address is window*8 when any of `h_req_be[3:0]` is set, otherwise window*8+4. The lane enables are that half of `h_req_be`. The returned data lands in that half of `h_rsp_data`, and the other half reads zero.
- R2: A read with enables in both halves goes out as two transactions. The lower one (window*8, `h_req_be[3:0]`) comes first. The upper one (window*8+4, `h_req_be[7:4]`) is not presented until the lower completion has returned.
- R3: For a split read, the lower completion data appears in `h_rsp_data[31:0]` and the upper in `h_rsp_data[63:32]`. `h_rsp_valid` pulses for exactly one cycle, in the cycle after the final completion.
- R4: `h_rsp_err` is the OR of the error flags of every completion that belongs to the request.
- R5: A write is never split. It goes out as one transaction whose lane is chosen as in R1, with the matching 32-bit half of `h_req_wdata`. Its response pulses only in the cycle after its completion, with zero data.
- R6: `h_req_ready` is low from the cycle after a request is accepted until the cycle after its response pulse.
- R7: A downstream-side request triggers a memory read at address 0x000C0000. `m_rd_valid` is held until `m_rd_ready`.
- R8: In the cycle after `m_rd_done`, `u_cpl_valid` pulses for one cycle with `u_cpl_status` = 3'b001, the unsupported-request code. Until then `u_req_ready` stays low.
- R9: While `d_req_valid` is high and `d_req_ready` is low, the downstream request (address, enables, write flag, data) does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_req_valid | input | 1 | Host request present |
| h_req_ready | output | 1 | Block can accept a host request |
| h_req_write | input | 1 | 1 = I/O write, 0 = I/O read |
| h_req_win | input | AW | 8-byte window index |
| h_req_be | input | 8 | Byte enables over the window |
| h_req_wdata | input | 64 | Write data over the window |
| h_rsp_valid | output | 1 | One-cycle host response |
| h_rsp_data | output | 64 | Merged read data |
| h_rsp_err | output | 1 | Error in any completion |
| d_req_valid | output | 1 | Downstream lane request present |
| d_req_ready | input | 1 | Downstream takes the request |
| d_req_write | output | 1 | Lane request is a write |
| d_req_addr | output | AW+3 | Byte address, 4-byte aligned |
| d_req_be | output | 4 | Lane byte enables |
| d_req_wdata | output | 32 | Lane write data |
| d_cpl_valid | input | 1 | Downstream completion |
| d_cpl_data | input | 32 | Completion data |
| d_cpl_err | input | 1 | Completion error flag |
| u_req_valid | input | 1 | Downstream-side I/O or configuration request |
| u_req_ready | output | 1 | Block can take such a request |
| m_rd_valid | output | 1 | Dummy memory read present |
| m_rd_ready | input | 1 | Memory side takes the read |
| m_rd_addr | output | 32 | Dummy read address |
| m_rd_done | input | 1 | Dummy read finished |
| u_cpl_valid | output | 1 | Completion for the stray request |
| u_cpl_status | output | 3 | Completion status |

## Verification
The bench sweeps all 255 non-zero enable patterns for reads, and every single-half pattern for writes. It stalls the downstream ready and delays completions while doing so. These cases catch several faults:
- A design that mis-detects a crossing would send one transaction where two are owed, or two where one is owed.
- A design that issues the upper half early would show `d_req_valid` during the wait for the lower completion.
- One that swaps halves while merging, or drops an error flag from either half, returns wrong data or a clear error bit.
- A write that is treated as posted would respond before its completion.

A stray downstream request is checked for the fixed address, a held read, and the unsupported-request code arriving only after the read finishes.

// File: rtl/io_split_bridge.sv
module io_split_bridge #(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_req_valid,
  output logic          h_req_ready,
  input  logic          h_req_write,
  input  logic [AW-1:0] h_req_win,
  input  logic [7:0]    h_req_be,
  input  logic [63:0]   h_req_wdata,
  output logic          h_rsp_valid,
  output logic [63:0]   h_rsp_data,
  output logic          h_rsp_err,
  output logic          d_req_valid,
  input  logic          d_req_ready,
  output logic          d_req_write,
  output logic [AW+2:0] d_req_addr,
  output logic [3:0]    d_req_be,
  output logic [31:0]   d_req_wdata,
  input  logic          d_cpl_valid,
  input  logic [31:0]   d_cpl_data,
  input  logic          d_cpl_err,
  input  logic          u_req_valid,
  output logic          u_req_ready,
  output logic          m_rd_valid,
  input  logic          m_rd_ready,
  output logic [31:0]   m_rd_addr,
  input  logic          m_rd_done,
  output logic          u_cpl_valid,
  output logic [2:0]    u_cpl_status
);
  localparam logic [31:0] DUMMY_ADDR = 32'h000C_0000;
  localparam logic [2:0]  ST_UNSUP   = 3'b001;

  typedef enum logic [1:0] {H_IDLE, H_ISSUE, H_WAIT, H_RESP} h_st_t;
  typedef enum logic [1:0] {U_IDLE, U_READ, U_WAIT, U_CPL} u_st_t;

  h_st_t          hst;
  u_st_t          ust;
  logic           wr_q, hi_q, split_q, err_q;
  logic [AW-1:0]  win_q;
  logic [7:0]     be_q;
  logic [63:0]    wd_q, acc_q;

  wire lo_any = |h_req_be[3:0];
  wire hi_any = |h_req_be[7:4];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hst     <= H_IDLE;
      wr_q    <= 1'b0;
      hi_q    <= 1'b0;
      split_q <= 1'b0;
      err_q   <= 1'b0;
      win_q   <= '0;
      be_q    <= '0;
      wd_q    <= '0;
      acc_q   <= '0;
    end else begin
      case (hst)
        H_IDLE: if (h_req_valid) begin
          wr_q    <= h_req_write;
          win_q   <= h_req_win;
          be_q    <= h_req_be;
          wd_q    <= h_req_wdata;
          hi_q    <= !lo_any;
          split_q <= lo_any && hi_any && !h_req_write;
          err_q   <= 1'b0;
          acc_q   <= '0;
          hst     <= H_ISSUE;
        end
        H_ISSUE: if (d_req_ready) hst <= H_WAIT;
        H_WAIT: if (d_cpl_valid) begin
          err_q <= err_q | d_cpl_err;
          if (!wr_q) begin
            if (hi_q) acc_q[63:32] <= d_cpl_data;
            else      acc_q[31:0]  <= d_cpl_data;
          end
          if (split_q && !hi_q) begin
            hi_q <= 1'b1;
            hst  <= H_ISSUE;
          end else begin
            hst <= H_RESP;
          end
        end
        default: hst <= H_IDLE;
      endcase
    end
  end

  assign h_req_ready = (hst == H_IDLE);
  assign h_rsp_valid = (hst == H_RESP);
  assign h_rsp_data  = acc_q;
  assign h_rsp_err   = err_q;
  assign d_req_valid = (hst == H_ISSUE);
  assign d_req_write = wr_q;
  assign d_req_addr  = {win_q, hi_q, 2'b00};
  assign d_req_be    = hi_q ? be_q[7:4] : be_q[3:0];
  assign d_req_wdata = hi_q ? wd_q[63:32] : wd_q[31:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ust <= U_IDLE;
    end else begin
      case (ust)
        U_IDLE:  if (u_req_valid) ust <= U_READ;
        U_READ:  if (m_rd_ready)  ust <= U_WAIT;
        U_WAIT:  if (m_rd_done)   ust <= U_CPL;
        default: ust <= U_IDLE;
      endcase
    end
  end

  assign u_req_ready  = (ust == U_IDLE);
  assign m_rd_valid   = (ust == U_READ);
  assign m_rd_addr    = DUMMY_ADDR;
  assign u_cpl_valid  = (ust == U_CPL);
  assign u_cpl_status = u_cpl_valid ? ST_UNSUP : 3'b000;
endmodule

// File: rtl/io_split_bridge_chk.sv
module io_split_bridge_chk #(
  parameter int AW = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          h_req_ready,
  input logic          h_rsp_valid,
  input logic          d_req_valid,
  input logic          d_req_ready,
  input logic          d_req_write,
  input logic [AW+2:0] d_req_addr,
  input logic [3:0]    d_req_be,
  input logic          d_cpl_valid,
  input logic          u_req_ready,
  input logic          m_rd_valid,
  input logic          m_rd_ready,
  input logic          m_rd_done,
  input logic          u_cpl_valid
);
  a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    d_req_valid && !d_req_ready |=> d_req_valid && $stable(d_req_addr) && $stable(d_req_be) && $stable(d_req_write));

  a_r3_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    h_rsp_valid |=> !h_rsp_valid);

  a_r5_rsp_after_cpl: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(h_rsp_valid) |-> $past(d_cpl_valid));

  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    h_req_ready |-> !d_req_valid && !h_rsp_valid);

  a_r7_rd_held: assert property (@(posedge clk) disable iff (!rst_n)
    m_rd_valid && !m_rd_ready |=> m_rd_valid);

  a_r8_cpl_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(u_cpl_valid) |-> $past(m_rd_done) && !u_req_ready);
endmodule

bind io_split_bridge io_split_bridge_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .h_req_ready(h_req_ready), .h_rsp_valid(h_rsp_valid),
  .d_req_valid(d_req_valid), .d_req_ready(d_req_ready), .d_req_write(d_req_write),
  .d_req_addr(d_req_addr), .d_req_be(d_req_be), .d_cpl_valid(d_cpl_valid),
  .u_req_ready(u_req_ready), .m_rd_valid(m_rd_valid), .m_rd_ready(m_rd_ready),
  .m_rd_done(m_rd_done), .u_cpl_valid(u_cpl_valid)
);

// File: tb/io_split_bridge_tb.sv
module io_split_bridge_tb;
  localparam int AW = 13;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic          h_req_valid = 0, h_req_write = 0;
  logic [AW-1:0] h_req_win = '0;
  logic [7:0]    h_req_be = '0;
  logic [63:0]   h_req_wdata = '0;
  logic          h_req_ready, h_rsp_valid, h_rsp_err;
  logic [63:0]   h_rsp_data;
  logic          d_req_valid, d_req_write;
  logic          d_req_ready = 0;
  logic [AW+2:0] d_req_addr;
  logic [3:0]    d_req_be;
  logic [31:0]   d_req_wdata;
  logic          d_cpl_valid = 0, d_cpl_err = 0;
  logic [31:0]   d_cpl_data = '0;
  logic          u_req_valid = 0, m_rd_ready = 0, m_rd_done = 0;
  logic          u_req_ready, m_rd_valid, u_cpl_valid;
  logic [31:0]   m_rd_addr;
  logic [2:0]    u_cpl_status;

  io_split_bridge #(.AW(AW)) u_dut (.*);

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic lane(input logic [AW+2:0] ea, input logic [3:0] ebe, input bit ew,
                      input logic [31:0] ewd, input int stall, input int lat,
                      input logic [31:0] cdat, input bit cerr);
    chk(d_req_valid === 1'b1, "R2 lane request present", d_req_valid, 1);
    chk(d_req_addr === ea, "R1 lane address", d_req_addr, ea);
    chk(d_req_be === ebe, "R1 lane enables", d_req_be, ebe);
    chk(d_req_write === ew, "R5 lane write flag", d_req_write, ew);
    if (ew) chk(d_req_wdata === ewd, "R5 lane write data", d_req_wdata, ewd);
    for (int i = 0; i < stall; i++) begin
      tick();
      chk(d_req_valid === 1'b1 && d_req_addr === ea && d_req_be === ebe, "R9 held under stall", d_req_addr, ea);
    end
    d_req_ready = 1; tick(); d_req_ready = 0;
    for (int i = 0; i < lat; i++) begin
      chk(d_req_valid === 1'b0, "R2 no request before completion", d_req_valid, 0);
      chk(h_rsp_valid === 1'b0, "R5 no early response", h_rsp_valid, 0);
      tick();
    end
    d_cpl_valid = 1; d_cpl_data = cdat; d_cpl_err = cerr;
    tick();
    d_cpl_valid = 0; d_cpl_err = 0;
  endtask

  task automatic host(input bit w, input logic [AW-1:0] win, input logic [7:0] be, input int stall, input int lat);
    bit lo = |be[3:0], hi = |be[7:4];
    logic [31:0] dl = 32'h1357_0000 + 32'(be) * 32'd97;
    logic [31:0] dh = 32'hC0DE_0000 ^ (32'(be) << 4);
    bit el = be[0] ^ be[5], eh = be[2] & be[7];
    logic [63:0] wd = {32'hA5A5_0000 | 32'(be), 32'h5A5A_0000 | 32'(~be)};
    logic [63:0] exp_d = '0;
    bit exp_e = 0;
    logic [AW+2:0] base = {win, 3'b000};
    chk(h_req_ready === 1'b1, "R6 ready when idle", h_req_ready, 1);
    h_req_valid = 1; h_req_write = w; h_req_win = win; h_req_be = be; h_req_wdata = wd;
    tick();
    h_req_valid = 0;
    chk(h_req_ready === 1'b0, "R6 busy after accept", h_req_ready, 0);
    if (w || !(lo && hi)) begin
      if (lo) begin
        lane(base, be[3:0], w, wd[31:0], stall, lat, dl, el);
        if (!w) exp_d[31:0] = dl;
        exp_e = el;
      end else begin
        lane(base + 4, be[7:4], w, wd[63:32], stall, lat, dh, eh);
        if (!w) exp_d[63:32] = dh;
        exp_e = eh;
      end
    end else begin
      lane(base, be[3:0], 0, '0, stall, lat, dl, el);
      chk(h_rsp_valid === 1'b0, "R3 no response after first half", h_rsp_valid, 0);
      lane(base + 4, be[7:4], 0, '0, stall, lat, dh, eh);
      exp_d = {dh, dl};
      exp_e = el | eh;
    end
    chk(h_rsp_valid === 1'b1, w ? "R5 write response" : "R3 read response", h_rsp_valid, 1);
    chk(h_rsp_data === exp_d, w ? "R5 write zero data" : "R3 R1 merged data", h_rsp_data, exp_d);
    chk(h_rsp_err === exp_e, "R4 error merge", h_rsp_err, exp_e);
    chk(h_req_ready === 1'b0, "R6 busy during response", h_req_ready, 0);
    tick();
    chk(h_rsp_valid === 1'b0, "R3 single pulse", h_rsp_valid, 0);
    chk(h_req_ready === 1'b1, "R6 ready after response", h_req_ready, 1);
  endtask

  task automatic stray(input int st, input int lat);
    chk(u_req_ready === 1'b1, "R8 upstream ready", u_req_ready, 1);
    u_req_valid = 1; tick(); u_req_valid = 0;
    chk(m_rd_valid === 1'b1, "R7 dummy read issued", m_rd_valid, 1);
    chk(m_rd_addr === 32'h000C_0000, "R7 dummy address", m_rd_addr, 32'h000C_0000);
    for (int i = 0; i < st; i++) begin
      tick();
      chk(m_rd_valid === 1'b1, "R7 read held", m_rd_valid, 1);
    end
    m_rd_ready = 1; tick(); m_rd_ready = 0;
    for (int i = 0; i < lat; i++) begin
      chk(u_cpl_valid === 1'b0 && u_req_ready === 1'b0, "R8 no early completion", u_cpl_valid, 0);
      tick();
    end
    m_rd_done = 1; tick(); m_rd_done = 0;
    chk(u_cpl_valid === 1'b1 && u_cpl_status === 3'b001, "R8 unsupported completion", u_cpl_status, 3'b001);
    tick();
    chk(u_cpl_valid === 1'b0 && u_req_ready === 1'b1, "R8 single completion pulse", u_cpl_valid, 0);
  endtask

  initial begin
    repeat (3) tick();
    chk(h_req_ready === 1'b1 && d_req_valid === 1'b0 && h_rsp_valid === 1'b0, "R6 reset state", d_req_valid, 0);
    rst_n = 1;
    tick();
    for (int b = 1; b < 256; b++) host(0, AW'(3 + b * 37), 8'(b), b % 3, b % 4);
    for (int b = 1; b < 256; b++)
      if (!((|b[3:0]) && (|b[7:4]))) host(1, AW'(b * 11), 8'(b), (b + 1) % 3, b % 3);
    host(0, '1, 8'hFF, 0, 0);
    host(0, '0, 8'h18, 2, 1);
    stray(0, 0);
    stray(3, 2);
    finished = 1;
  end

  initial begin
    int cyc = 0;
    while (!finished && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule